// File: doc/BRIEF.md
# Value-Inlining Register Rename Table

This block is the rename map of an out-of-order core, organised as a RAM with one entry per logical register. An entry normally holds the tag of the physical register that will carry the latest value of its logical register. When a result turns out to be small enough to fit a short signed field, the writeback stage can put the value itself into the entry. Later consumers then take the operand directly from the map as an immediate, and the physical register that held the value can be given back to the free pool early.

The rename stage writes new pointers for destinations. The writeback stage presents a narrow-write request with the logical register, the producing physical tag and the full result. The block checks whether the result fits. It accepts the request only if the entry still points to that same physical tag, so that a later remapping is never overwritten. For each accepted inline write, the replaced tag appears on a release output one cycle later. The free list must tolerate the same tag being released a second time, when the next writer of that logical register commits.

Read ports are combinational. Each returns a flag that tells a pointer from a value, the tag when the entry is a pointer, and the sign-extended value when the entry is inlined.

Top module: `vi_rename_map`

## Requirements
- R1: While reset is low, and after it is released, entry i points to physical tag i with the inline flag clear.
- R2: A rename write (`ren_we`) to logical register L with tag T has this effect from the next cycle: reads of L return flag 0, tag T and immediate 0.
- R3: A narrow write is accepted when all of the following hold: the value lies in the signed range -64..63 (for INLW=7), the entry is a pointer, and its tag equals `wb_ptag`. From the next cycle, reads return flag 1, tag 0 and the value sign-extended to DATAW bits.
- R4: A narrow write whose value lies outside the signed INLW-bit range is dropped. The entry is unchanged and no release occurs.
- R5: A narrow write whose `wb_ptag` differs from the tag currently held in the entry is dropped. The entry is unchanged and no release occurs.
- R6: If a rename write and a narrow write target the same logical register in the same cycle, the rename write takes effect and the narrow write is dropped without release.
- R7: One cycle after an accepted narrow write, `rel_valid` is 1 and `rel_ptag` equals that write's `wb_ptag`. In every other cycle, `rel_valid` is 0.
- R8: A narrow write to an entry that already holds an inlined value is dropped. The stored value is kept and no release occurs.
- R9: All read ports are independent. Each port reflects the entry its own address selects, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_lreg | input | NRD*LW | Packed logical addresses, one per read port |
| rd_inl | output | NRD | Per-port inline flag |
| rd_tag | output | NRD*TAGW | Per-port physical tag (0 when inlined) |
| rd_imm | output | NRD*DATAW | Per-port sign-extended value (0 when pointer) |
| ren_we | input | 1 | Rename write enable |
| ren_lreg | input | LW | Rename destination logical register |
| ren_ptag | input | TAGW | Newly allocated physical tag |
| wb_valid | input | 1 | Narrow-write request from writeback |
| wb_lreg | input | LW | Logical destination of the result |
| wb_ptag | input | TAGW | Physical tag that produced the result |
| wb_value | input | DATAW | Full-width result value |
| rel_valid | output | 1 | Early release strobe |
| rel_ptag | output | TAGW | Tag being released |

## Verification
The embedded properties assume three things about the inputs. Reset is held for at least one clock edge before it is released. Logical addresses stay below NLOG. A writeback request names a tag that the rename stage allocated earlier, so a tag match means the producer is still current. The stimulus keeps within these assumptions by driving addresses from the low LW bits, holding reset for several cycles, and choosing writeback tags mostly from the bench model's current mapping. Deliberately stale tags are used only to exercise the drop path. Random values cluster around the inline boundary so that both sides of the range check are hit often.

// File: rtl/vi_rename_map.sv
module vi_rename_map #(
  parameter int NLOG  = 32,
  parameter int TAGW  = 6,
  parameter int INLW  = 7,
  parameter int DATAW = 32,
  parameter int NRD   = 3,
  localparam int LW   = $clog2(NLOG),
  localparam int FW   = (INLW > TAGW) ? INLW : TAGW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NRD*LW-1:0]    rd_lreg,
  output logic [NRD-1:0]       rd_inl,
  output logic [NRD*TAGW-1:0]  rd_tag,
  output logic [NRD*DATAW-1:0] rd_imm,
  input  logic                 ren_we,
  input  logic [LW-1:0]        ren_lreg,
  input  logic [TAGW-1:0]      ren_ptag,
  input  logic                 wb_valid,
  input  logic [LW-1:0]        wb_lreg,
  input  logic [TAGW-1:0]      wb_ptag,
  input  logic [DATAW-1:0]     wb_value,
  output logic                 rel_valid,
  output logic [TAGW-1:0]      rel_ptag
);

  logic [FW-1:0]   fld_q [NLOG];
  logic [NLOG-1:0] inl_q;

  wire [DATAW-INLW:0] upper = wb_value[DATAW-1:INLW-1];
  wire fits  = (&upper) | ~(|upper);
  wire hit   = !inl_q[wb_lreg] && (fld_q[wb_lreg][TAGW-1:0] == wb_ptag);
  wire clash = ren_we && (ren_lreg == wb_lreg);
  wire take  = wb_valid && fits && hit && !clash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOG; i++) fld_q[i] <= FW'(i % (1 << TAGW));
      inl_q     <= '0;
      rel_valid <= 1'b0;
      rel_ptag  <= '0;
    end else begin
      if (ren_we) begin
        fld_q[ren_lreg] <= FW'(ren_ptag);
        inl_q[ren_lreg] <= 1'b0;
      end
      if (take) begin
        fld_q[wb_lreg] <= FW'(wb_value[INLW-1:0]);
        inl_q[wb_lreg] <= 1'b1;
      end
      rel_valid <= take;
      rel_ptag  <= take ? wb_ptag : '0;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    wire [LW-1:0]   lr = rd_lreg[g*LW +: LW];
    wire [INLW-1:0] v  = fld_q[lr][INLW-1:0];
    assign rd_inl[g] = inl_q[lr];
    assign rd_tag[g*TAGW +: TAGW]   = inl_q[lr] ? '0 : fld_q[lr][TAGW-1:0];
    assign rd_imm[g*DATAW +: DATAW] = inl_q[lr] ? {{(DATAW-INLW){v[INLW-1]}}, v} : '0;
  end

  a_r2_rename_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    ren_we |=> (!inl_q[$past(ren_lreg)] && fld_q[$past(ren_lreg)][TAGW-1:0] == $past(ren_ptag)));

  a_r3_inline_set: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> inl_q[$past(wb_lreg)]);

  a_r4_wide_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && ($signed(wb_value) > $signed(DATAW'((1 << (INLW-1)) - 1)) ||
                  $signed(wb_value) < -$signed(DATAW'(1 << (INLW-1))))) |=> !rel_valid);

  a_r5_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !hit) |=> !rel_valid);

  a_r6_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && ren_we && ren_lreg == wb_lreg) |=> (!rel_valid && !inl_q[$past(wb_lreg)]));

  a_r7_release_tag: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_ptag == $past(wb_ptag) && $past(wb_valid)));

endmodule

// File: tb/sim_vi_rename_map.sv
module sim_vi_rename_map;
  localparam int NLOG = 32, TAGW = 6, INLW = 7, DATAW = 32, NRD = 3, LW = 5;

  logic clk = 0, rst_n = 0;
  logic [NRD*LW-1:0] rd_lreg = '0;
  logic [NRD-1:0] rd_inl;
  logic [NRD*TAGW-1:0] rd_tag;
  logic [NRD*DATAW-1:0] rd_imm;
  logic ren_we = 0, wb_valid = 0;
  logic [LW-1:0] ren_lreg = '0, wb_lreg = '0;
  logic [TAGW-1:0] ren_ptag = '0, wb_ptag = '0;
  logic [DATAW-1:0] wb_value = '0;
  logic rel_valid;
  logic [TAGW-1:0] rel_ptag;

  always #2 clk = ~clk;

  vi_rename_map u0 (.*);

  int vecs = 0, bad = 0;
  int m_tag [NLOG];
  bit m_inl [NLOG];
  int m_val [NLOG];
  bit m_rel;
  int m_rtag;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_reads(input string req);
    for (int p = 0; p < NRD; p++) begin
      int l = int'(rd_lreg[p*LW +: LW]);
      int et = m_inl[l] ? 0 : m_tag[l];
      int ei = m_inl[l] ? m_val[l] : 0;
      chk(rd_inl[p] == m_inl[l], req, int'(rd_inl[p]), int'(m_inl[l]));
      chk(int'(rd_tag[p*TAGW +: TAGW]) == et, req, int'(rd_tag[p*TAGW +: TAGW]), et);
      chk($signed(rd_imm[p*DATAW +: DATAW]) == ei, req, $signed(rd_imm[p*DATAW +: DATAW]), ei);
    end
  endtask

  task automatic step(input bit rw, input int rl, input int rp,
                      input bit wv, input int wl, input int wp, input int val,
                      input int a0, input int a1, input int a2, input string req);
    bit fits, tk;
    ren_we = rw; ren_lreg = LW'(rl); ren_ptag = TAGW'(rp);
    wb_valid = wv; wb_lreg = LW'(wl); wb_ptag = TAGW'(wp); wb_value = DATAW'(val);
    rd_lreg = {LW'(a2), LW'(a1), LW'(a0)};
    #1;
    check_reads(req);
    @(posedge clk);
    fits = (val >= -(1 << (INLW-1))) && (val < (1 << (INLW-1)));
    tk = wv && fits && !m_inl[wl] && m_tag[wl] == wp && !(rw && rl == wl);
    if (rw) begin m_tag[rl] = rp; m_inl[rl] = 0; end
    if (tk) begin m_inl[wl] = 1; m_val[wl] = val; end
    m_rel = tk; m_rtag = wp;
    @(negedge clk);
    chk(rel_valid == m_rel, {req, " R7"}, int'(rel_valid), int'(m_rel));
    if (m_rel) chk(int'(rel_ptag) == m_rtag, {req, " R7"}, int'(rel_ptag), m_rtag);
  endtask

  task automatic idle(input int a0, input int a1, input int a2, input string req);
    step(0, 0, 0, 0, 0, 0, 0, a0, a1, a2, req);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NLOG; i++) begin m_tag[i] = i; m_inl[i] = 0; m_val[i] = 0; end
    repeat (4) @(negedge clk);
    #1;
    check_reads("R1");
    chk(rel_valid == 0, "R1", int'(rel_valid), 0);
    rst_n = 1;
    @(negedge clk);
    idle(0, 1, 31, "R1");
    idle(17, 5, 30, "R9");
    step(1, 5, 40, 0, 0, 0, 0, 5, 5, 6, "R2");
    idle(5, 4, 6, "R2");
    step(0, 0, 0, 1, 5, 40, -3, 5, 0, 0, "R3");
    idle(5, 5, 1, "R3");
    step(0, 0, 0, 1, 5, 40, 2, 5, 0, 0, "R8");
    idle(5, 2, 3, "R8");
    step(1, 6, 41, 0, 0, 0, 0, 6, 0, 0, "R2");
    step(0, 0, 0, 1, 6, 41, 64, 6, 0, 0, "R4");
    step(0, 0, 0, 1, 6, 41, -65, 6, 0, 0, "R4");
    idle(6, 5, 0, "R4");
    step(0, 0, 0, 1, 6, 41, -64, 6, 0, 0, "R3");
    idle(6, 5, 7, "R3");
    step(1, 9, 50, 0, 0, 0, 0, 9, 0, 0, "R2");
    step(0, 0, 0, 1, 9, 50, 63, 9, 0, 0, "R3");
    idle(9, 6, 5, "R3");
    step(1, 7, 42, 0, 0, 0, 0, 7, 0, 0, "R2");
    step(1, 7, 43, 0, 0, 0, 0, 7, 0, 0, "R2");
    step(0, 0, 0, 1, 7, 42, 1, 7, 0, 0, "R5");
    idle(7, 7, 7, "R5");
    step(1, 8, 44, 1, 8, 8, 1, 8, 0, 0, "R6");
    idle(8, 8, 0, "R6");
    step(1, 5, 45, 0, 0, 0, 0, 5, 0, 0, "R2");
    idle(5, 6, 9, "R2");
    for (int n = 0; n < 4000; n++) begin
      int rl = $urandom_range(0, NLOG-1);
      int wl = $urandom_range(0, NLOG-1);
      int wp = ($urandom_range(0, 3) != 0) ? m_tag[wl] : $urandom_range(0, 63);
      int v  = $urandom_range(0, 3) == 0 ? int'($urandom) : $urandom_range(0, 160) - 80;
      step($urandom_range(0, 3) == 0, rl, $urandom_range(0, 63),
           $urandom_range(0, 1) == 1, wl, wp, v,
           $urandom_range(0, NLOG-1), $urandom_range(0, NLOG-1), wl, "R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule